// File: doc/BRIEF.md
# Timer Output Compare Waveform Unit

This block pairs a free-running up-counter with two compare slots to produce one waveform output and a sticky compare interrupt request. The counter runs from zero up to a programmable period and then wraps to zero. Software loads a compare value into slot A or slot B through a small register write port. A match on slot A drives the waveform high and a match on slot B drives it low, so the two values set the edges of a pulse within each period.

A compare write takes effect at once while the timer is stopped. While the timer runs, the write is held in a pending buffer and reaches the slot only when the counter wraps, so a period never sees a half-updated pulse. A trigger-enable bit decides whether matches may move the output. Matches always raise their flag and the interrupt request, whether or not the output follows them.

Top module: `cmp_wave_unit`

## Requirements
- R1: While running, `cnt_out` steps by one per clock and returns to 0 on the clock after it reaches a value at or above the period; while stopped it holds its value.
- R2: With the timer stopped, a write to select 1 (slot A) or select 2 (slot B) loads that slot on the same clock edge, and any pending value for that slot is dropped.
- R3: With the timer running, a compare write is held and loads its slot on the clock edge where the counter wraps to 0; until then the slot keeps its old value.
- R4: A slot whose value exceeds the period never matches, so the waveform stays at a fixed level and its flag is not set.
- R5: When one slot is out of range and the other is within the period, the in-range slot still matches and raises its flag and `irq`.
- R6: With trigger-enable (control bit 1) at 0, matches do not change `wave_out`, but `match_flag` (bit 0 for slot A, bit 1 for slot B) and `irq` are still set.
- R7: With the timer running and trigger-enable at 1, `wave_out` goes high on the clock after the counter equals slot A and low on the clock after it equals slot B.
- R8: If both slots hold the same value, a match drives `wave_out` low.
- R9: A control write (select 3) with trigger-enable at 1, made while the timer is stopped, returns `wave_out` to its initial low level.
- R10: `irq` and `match_flag` stay set until a control write with the clear bit (bit 2) at 1; a match in the same cycle as the clear wins.
- R11: After reset the counter, period, both slots, control bits, flags, `irq` and `wave_out` are all 0. Control bit 0 is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 period, 1 slot A, 2 slot B, 3 control |
| wr_data | input | W | Write data; for control, bit 0 run, bit 1 trigger-enable, bit 2 clear |
| cnt_out | output | W | Current counter value |
| wave_out | output | 1 | Waveform output |
| match_flag | output | 2 | Sticky match flags, bit 0 slot A, bit 1 slot B |
| irq | output | 1 | Sticky compare interrupt request |

## Verification
The assertions assume `wr_sel` and `wr_data` are stable and meaningful only when `wr_en` is high. They also assume the period is not lowered below the current count in a way that would need more than one wrap to recover; the range check is written against a wrap rule of "at or above the period". The stimulus issues one write per clock, driven on the falling edge. It changes the period only while the timer is stopped, and keeps the compare values within the counter width. Deliberate equal or out-of-range slot values are used only in the phases that exercise R4, R5 and R8.

// File: rtl/cmp_wave_pkg.sv
package cmp_wave_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CMP_A  = 2'd1,
    SEL_CMP_B  = 2'd2,
    SEL_CTRL   = 2'd3
  } regsel_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_TRIG = 1;
  localparam int CTL_CLR  = 2;
  localparam int NUM_SLOT = 2;
endpackage

// File: rtl/cwu_counter.sv
module cwu_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic at_end(input logic [W-1:0] c, input logic [W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] p);
    return at_end(c, p) ? '0 : c + 1'b1;
  endfunction

  assign wrap = run && at_end(cnt, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= step(cnt, period);
  end
endmodule

// File: rtl/cwu_cmp_slot.sv
module cwu_cmp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wrap,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] lat,
  output logic         hit
);
  logic [W-1:0] pend;
  logic         pend_v;
  logic         load_now;
  logic         load_buf;

  function automatic logic in_range(input logic [W-1:0] v, input logic [W-1:0] p);
    return v <= p;
  endfunction

  function automatic logic is_hit(input logic r, input logic [W-1:0] c,
                                  input logic [W-1:0] v, input logic [W-1:0] p);
    return r && (c == v) && in_range(v, p);
  endfunction

  assign load_now = wr && !run;
  assign load_buf = wr && run;
  assign hit      = is_hit(run, cnt, lat, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (load_now) begin
      lat    <= wr_data;
      pend_v <= 1'b0;
    end else begin
      if (wrap && pend_v) lat <= pend;
      if (load_buf) begin
        pend   <= wr_data;
        pend_v <= 1'b1;
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cwu_wave_ctl.sv
module cwu_wave_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       trig,
  input  logic       init_req,
  input  logic       clr,
  input  logic [1:0] hit,
  output logic       wave,
  output logic [1:0] flags,
  output logic       irq
);
  function automatic logic next_wave(input logic cur, input logic act,
                                     input logic set_h, input logic clr_h);
    if (!act)  return cur;
    if (clr_h) return 1'b0;
    if (set_h) return 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave  <= 1'b0;
      flags <= 2'b00;
      irq   <= 1'b0;
    end else begin
      if (init_req) wave <= 1'b0;
      else          wave <= next_wave(wave, trig && run, hit[0], hit[1]);
      flags <= (clr ? 2'b00 : flags) | hit;
      irq   <= (clr ? 1'b0 : irq) | (|hit);
    end
  end
endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
  import cmp_wave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_out,
  output logic         wave_out,
  output logic [1:0]   match_flag,
  output logic         irq
);
  logic [W-1:0] period_q;
  logic         run_q;
  logic         trig_q;
  logic         wrap;
  logic         ctl_wr;
  logic         init_req;
  logic         clr_req;
  logic [1:0]   hit;
  logic [W-1:0] lat [NUM_SLOT];
  logic [W-1:0] lat_a;
  logic [W-1:0] lat_b;
  logic         hit_a;
  logic         hit_b;

  assign ctl_wr   = wr_en && (regsel_e'(wr_sel) == SEL_CTRL);
  assign init_req = ctl_wr && wr_data[CTL_TRIG] && !run_q;
  assign clr_req  = ctl_wr && wr_data[CTL_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      run_q    <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      if (wr_en && (regsel_e'(wr_sel) == SEL_PERIOD)) period_q <= wr_data;
      if (ctl_wr) begin
        run_q  <= wr_data[CTL_RUN];
        trig_q <= wr_data[CTL_TRIG];
      end
    end
  end

  cwu_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
    .cnt(cnt_out), .wrap(wrap)
  );

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam regsel_e MY_SEL = (i == 0) ? SEL_CMP_A : SEL_CMP_B;
    logic slot_wr;
    assign slot_wr = wr_en && (regsel_e'(wr_sel) == MY_SEL);
    cwu_cmp_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .run(run_q), .wrap(wrap),
      .wr(slot_wr), .wr_data(wr_data), .period(period_q),
      .cnt(cnt_out), .lat(lat[i]), .hit(hit[i])
    );
  end

  assign lat_a = lat[0];
  assign lat_b = lat[1];
  assign hit_a = hit[0];
  assign hit_b = hit[1];

  cwu_wave_ctl u_wave (
    .clk(clk), .rst_n(rst_n), .run(run_q), .trig(trig_q),
    .init_req(init_req), .clr(clr_req), .hit(hit),
    .wave(wave_out), .flags(match_flag), .irq(irq)
  );
endmodule

// File: rtl/cwu_checker.sv
module cwu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic         run_q,
  input logic         trig_q,
  input logic [W-1:0] period_q,
  input logic [W-1:0] lat_a,
  input logic [W-1:0] lat_b,
  input logic         hit_a,
  input logic         hit_b,
  input logic [W-1:0] cnt_out,
  input logic         wave_out,
  input logic         irq
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_sel == 2'd3);

  AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> cnt_out == $past(cnt_out)); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_out >= period_q) |=> cnt_out == '0); // R1
  AST_STOPPED_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !run_q) |=> lat_a == $past(wr_data)); // R2
  AST_STOPPED_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !run_q) |=> lat_b == $past(wr_data)); // R2
  AST_OUT_OF_RANGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_a > period_q) |-> !hit_a); // R4
  AST_TRIG_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_q && !(ctl_wr && wr_data[1] && !run_q)) |=> $stable(wave_out)); // R6
  AST_HIT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a || hit_b) |=> irq); // R10
  AST_CLEAR_WINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && run_q && hit_b) |=> !wave_out); // R8
  AST_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[1] && !run_q) |=> !wave_out); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctl_wr && wr_data[2])) |=> irq); // R10
endmodule

bind cmp_wave_unit cwu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .run_q(run_q), .trig_q(trig_q), .period_q(period_q),
  .lat_a(lat_a), .lat_b(lat_b), .hit_a(hit_a), .hit_b(hit_b),
  .cnt_out(cnt_out), .wave_out(wave_out), .irq(irq)
);

// File: tb/cmp_wave_unit_tb.sv
module cmp_wave_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_out;
  logic         wave_out;
  logic [1:0]   match_flag;
  logic         irq;

  int checks = 0;
  int errors = 0;
  string phase = "R11";

  // reference model state
  int m_cnt, m_per, m_la, m_lb, m_pa, m_pb;
  int m_va, m_vb, m_run, m_trig, m_wave, m_fa, m_fb, m_irq;

  always #5 clk = ~clk;

  cmp_wave_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_out(cnt_out), .wave_out(wave_out), .match_flag(match_flag), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_la = 0; m_lb = 0; m_pa = 0; m_pb = 0;
      m_va = 0; m_vb = 0; m_run = 0; m_trig = 0; m_wave = 0;
      m_fa = 0; m_fb = 0; m_irq = 0;
    end else begin
      int ha, hb, wr, ctl, clr;
      int n_cnt, n_wave, n_la, n_lb, n_pa, n_pb, n_va, n_vb;
      ha  = (m_run != 0 && m_cnt == m_la && m_la <= m_per) ? 1 : 0;
      hb  = (m_run != 0 && m_cnt == m_lb && m_lb <= m_per) ? 1 : 0;
      wr  = (m_run != 0 && m_cnt >= m_per) ? 1 : 0;
      ctl = (wr_en && wr_sel == 2'd3) ? 1 : 0;
      clr = (ctl != 0 && wr_data[2]) ? 1 : 0;
      n_wave = m_wave;
      if (ctl != 0 && wr_data[1] && m_run == 0) n_wave = 0;
      else if (m_trig != 0 && m_run != 0) begin
        if (hb != 0) n_wave = 0;
        else if (ha != 0) n_wave = 1;
      end
      n_cnt = m_cnt;
      if (m_run != 0) n_cnt = (wr != 0) ? 0 : m_cnt + 1;
      n_la = m_la; n_pa = m_pa; n_va = m_va;
      n_lb = m_lb; n_pb = m_pb; n_vb = m_vb;
      if (wr != 0 && m_va != 0) begin n_la = m_pa; n_va = 0; end
      if (wr != 0 && m_vb != 0) begin n_lb = m_pb; n_vb = 0; end
      if (wr_en && wr_sel == 2'd1) begin
        if (m_run == 0) begin n_la = int'(wr_data); n_va = 0; end
        else begin n_pa = int'(wr_data); n_va = 1; end
      end
      if (wr_en && wr_sel == 2'd2) begin
        if (m_run == 0) begin n_lb = int'(wr_data); n_vb = 0; end
        else begin n_pb = int'(wr_data); n_vb = 1; end
      end
      if (wr_en && wr_sel == 2'd0) m_per = int'(wr_data);
      if (ctl != 0) begin m_run = wr_data[0]; m_trig = wr_data[1]; end
      m_fa  = ((clr != 0) ? 0 : m_fa) | ha;
      m_fb  = ((clr != 0) ? 0 : m_fb) | hb;
      m_irq = ((clr != 0) ? 0 : m_irq) | ha | hb;
      m_wave = n_wave; m_cnt = n_cnt;
      m_la = n_la; m_pa = n_pa; m_va = n_va;
      m_lb = n_lb; m_pb = n_pb; m_vb = n_vb;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1",  "cnt_out",  int'(cnt_out), m_cnt);
      chk(phase, "wave_out", int'(wave_out), m_wave);
      chk("R10", "flag_a",   int'(match_flag[0]), m_fa);
      chk("R10", "flag_b",   int'(match_flag[1]), m_fb);
      chk("R10", "irq",      int'(irq), m_irq);
    end
  end

  task automatic wr(input logic [1:0] s, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11: reset state
    chk("R11", "cnt_out",  int'(cnt_out), 0);
    chk("R11", "wave_out", int'(wave_out), 0);
    chk("R11", "irq",      int'(irq), 0);
    chk("R11", "flags",    int'(match_flag), 0);

    // R2: stopped loads, then R7 basic pulse
    phase = "R2";
    wr(2'd0, 9); wr(2'd1, 2); wr(2'd2, 6); wr(2'd3, 2);
    phase = "R7";
    wr(2'd3, 3);
    idle(4);
    chk("R7", "wave high after A match", int'(wave_out), 1);
    idle(5);
    chk("R7", "wave low after B match", int'(wave_out), 0);
    idle(20);

    // R3: running write buffered until wrap
    phase = "R3";
    wr(2'd1, 4);
    idle(30);

    // R1: stop holds the counter
    phase = "R1";
    wr(2'd3, 2);
    begin
      int held;
      held = int'(cnt_out);
      idle(5);
      chk("R1", "count held while stopped", int'(cnt_out), held);
    end

    // R5: slot B out of range, slot A still fires
    phase = "R5";
    wr(2'd3, 4);
    wr(2'd2, 20);
    wr(2'd3, 3);
    idle(25);
    chk("R5", "wave stuck high", int'(wave_out), 1);
    chk("R5", "irq from in-range slot", int'(irq), 1);

    // R4: both out of range, no match at all
    phase = "R4";
    wr(2'd3, 0);
    wr(2'd1, 30);
    wr(2'd3, 4);
    wr(2'd3, 1);
    idle(30);
    chk("R4", "irq stays low", int'(irq), 0);
    chk("R4", "flags stay low", int'(match_flag), 0);

    // R6: trigger off, matches flag but do not move output
    phase = "R6";
    wr(2'd3, 0);
    wr(2'd1, 3); wr(2'd2, 7);
    wr(2'd3, 1);
    idle(25);
    chk("R6", "flags set with trigger off", int'(match_flag), 3);
    chk("R6", "wave unchanged", int'(wave_out), 1);

    // R9: stopped control write with trigger returns output low
    phase = "R9";
    wr(2'd3, 0);
    wr(2'd3, 2);
    chk("R9", "wave back to initial", int'(wave_out), 0);

    // R10: clear bit
    phase = "R10";
    wr(2'd3, 4);
    chk("R10", "irq cleared", int'(irq), 0);
    idle(5);
    chk("R10", "irq stays clear", int'(irq), 0);

    // R8: equal values, low wins
    phase = "R8";
    wr(2'd1, 5); wr(2'd2, 5);
    wr(2'd3, 3);
    idle(25);
    chk("R8", "equal slots give low", int'(wave_out), 0);

    // R1: shorter period while running rule
    phase = "R1";
    wr(2'd3, 2);
    wr(2'd0, 4);
    wr(2'd1, 1); wr(2'd2, 3);
    wr(2'd3, 7);
    idle(20);
    wr(2'd3, 0);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule